// File: doc/BRIEF.md
# Filtered Bandwidth-Usage Monitor Slots

This block counts the bytes of memory traffic that belong to a chosen (partition, monitoring group) pair. It holds a small pool of monitor slots. Each slot carries a filter made of a partition ID and a monitoring group. Each cycle, every enabled slot whose filter equals the tags of the incoming transfer adds that transfer's byte count to its own counter. The slots form a pool that software assigns to the pairs it wants to watch. They are not storage indexed by partition ID, so two slots may watch the same pair.

Software reaches one slot at a time. It first writes the slot index into a select register. The filter, control, status and counter registers then act on that slot. The counter width is a build parameter and can be 31, 44 or 63 bits. A counter is read as two 32-bit words. Reading the low word captures the high word into a shadow, so the two words always belong to the same count. When a counter wraps, a sticky overflow flag is set. An optional interrupt line reports flags whose slot has interrupts enabled.

Register offsets (3-bit address): 0 select, 1 filter, 2 control, 3 status, 4 counter low word, 5 counter high word (shadow).

Top module: `bwmon`

## Requirements
- R1: After reset all counters, flags, enables and filters are zero, the select register is 0, the read data is 0 and the interrupt is low.
- R2: Writing offset 0 selects a slot. Filter, control, status and counter accesses affect and return only the selected slot.
- R3: An enabled slot adds the byte count of a valid transfer when the partition ID equals filter bits [15:0] and the monitoring group equals filter bits [23:16]. The new count is visible from the clock edge that samples the transfer.
- R4: A transfer leaves a slot's counter unchanged if the slot is disabled or if either tag differs from its filter. Control bit 0 is the enable and bit 1 is the interrupt enable; both read back.
- R5: Writing control bit 2 zeroes the selected counter and its overflow flag. A matching transfer in the same cycle is dropped, and bit 2 reads back as 0.
- R6: A read returns data in the cycle after the read strobe. Reading offset 4 returns counter bits [31:0] and captures bits [63:32] of the zero-extended counter into a shadow. Reading offset 5 returns the shadow, even if the counter has changed since the low-word read.
- R7: With a 31-bit counter, bit 31 of the low word and the whole high word read as 0.
- R8: A counter keeps its sum modulo 2^CNT_W. A wrap sets status bit 0, which stays set until software writes 1 to it.
- R9: The interrupt is high while any slot has both its overflow flag and its interrupt enable set.
- R10: Several slots with the same filter each count the same matching transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_valid | input | 1 | A transfer is present this cycle |
| xfer_part | input | PART_W | Partition ID of the transfer |
| xfer_grp | input | GRP_W | Monitoring group of the transfer |
| xfer_bytes | input | BYTES_W | Byte count of the transfer |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| ovf_irq | output | 1 | Overflow interrupt |

## Verification
A transfer or a register write that is driven before a rising edge has its effect on counters, flags and the interrupt at that edge. The bench therefore looks at the interrupt at the falling edge that follows. Read data is registered, so the word for a read strobe sampled at edge N is compared at the falling edge after edge N. The expected value comes from the bench model's state just before edge N. The shadow test separates the low-word read and the high-word read with more traffic, which shows that the high word is latched when the low word is read.

// File: rtl/bwmon_pkg.sv
package bwmon_pkg;
  typedef logic [2:0] reg_addr_t;
  localparam reg_addr_t OFS_SEL  = 3'd0;
  localparam reg_addr_t OFS_FILT = 3'd1;
  localparam reg_addr_t OFS_CTRL = 3'd2;
  localparam reg_addr_t OFS_STAT = 3'd3;
  localparam reg_addr_t OFS_CLO  = 3'd4;
  localparam reg_addr_t OFS_CHI  = 3'd5;
  localparam int CTRL_EN  = 0;
  localparam int CTRL_IE  = 1;
  localparam int CTRL_CLR = 2;
  localparam int FILT_GRP_LSB = 16;

  // lower and upper words of a zero-extended counter
  function automatic logic [31:0] low_word(input logic [63:0] c);
    return c[31:0];
  endfunction
  function automatic logic [31:0] high_word(input logic [63:0] c);
    return c[63:32];
  endfunction
endpackage

// File: rtl/bwmon_slot.sv
module bwmon_slot
  import bwmon_pkg::*;
#(
  parameter int PART_W  = 16,
  parameter int GRP_W   = 8,
  parameter int BYTES_W = 16,
  parameter int CNT_W   = 44
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_i,
  input  logic               wr_filt_i,
  input  logic               wr_ctrl_i,
  input  logic               wr_stat_i,
  input  logic [31:0]        wdata_i,
  input  logic               xv_i,
  input  logic [PART_W-1:0]  xpart_i,
  input  logic [GRP_W-1:0]   xgrp_i,
  input  logic [BYTES_W-1:0] xbytes_i,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               ovf_o,
  output logic               en_o,
  output logic               ie_o,
  output logic [PART_W-1:0]  fpart_o,
  output logic [GRP_W-1:0]   fgrp_o,
  output logic               hit_o,
  output logic               wrap_o,
  output logic               clr_o
);
  logic [CNT_W:0] sum_ext;
  logic           unused_wdata;

  assign unused_wdata = ^wdata_i;
  assign hit_o   = xv_i && en_o && (xpart_i == fpart_o) && (xgrp_i == fgrp_o);
  assign sum_ext = {1'b0, cnt_o} + (CNT_W+1)'(xbytes_i);
  assign wrap_o  = hit_o && sum_ext[CNT_W];
  assign clr_o   = sel_i && wr_ctrl_i && wdata_i[CTRL_CLR];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fpart_o <= '0;
      fgrp_o  <= '0;
      en_o    <= 1'b0;
      ie_o    <= 1'b0;
    end else begin
      if (sel_i && wr_filt_i) begin
        fpart_o <= wdata_i[PART_W-1:0];
        fgrp_o  <= wdata_i[FILT_GRP_LSB +: GRP_W];
      end
      if (sel_i && wr_ctrl_i) begin
        en_o <= wdata_i[CTRL_EN];
        ie_o <= wdata_i[CTRL_IE];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_o <= '0;
      ovf_o <= 1'b0;
    end else if (clr_o) begin
      cnt_o <= '0;
      ovf_o <= 1'b0;
    end else begin
      if (hit_o) cnt_o <= sum_ext[CNT_W-1:0];
      if (wrap_o) ovf_o <= 1'b1;
      else if (sel_i && wr_stat_i && wdata_i[0]) ovf_o <= 1'b0;
    end
  end
endmodule

// File: rtl/bwmon_rdmux.sv
module bwmon_rdmux
  import bwmon_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int PART_W    = 16,
  parameter int GRP_W     = 8,
  parameter int CNT_W     = 44,
  parameter int SEL_W     = 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                rd_i,
  input  reg_addr_t                           addr_i,
  input  logic [SEL_W-1:0]                    sel_i,
  input  logic                                sel_ok_i,
  input  logic [NUM_SLOTS-1:0][CNT_W-1:0]     cnt_all_i,
  input  logic [NUM_SLOTS-1:0]                ovf_i,
  input  logic [NUM_SLOTS-1:0]                en_i,
  input  logic [NUM_SLOTS-1:0]                ie_i,
  input  logic [NUM_SLOTS-1:0][PART_W-1:0]    fpart_i,
  input  logic [NUM_SLOTS-1:0][GRP_W-1:0]     fgrp_i,
  output logic [31:0]                         rdata_o,
  output logic                                rd_lo_o
);
  logic [63:0] cnt_sel;
  logic [31:0] shadow_q, rd_next, filt_word;

  always_comb begin
    cnt_sel   = '0;
    filt_word = '0;
    if (sel_ok_i) begin
      cnt_sel = 64'(cnt_all_i[sel_i]);
      filt_word[PART_W-1:0] = fpart_i[sel_i];
      filt_word[FILT_GRP_LSB +: GRP_W] = fgrp_i[sel_i];
    end
  end

  always_comb begin
    rd_next = '0;
    case (addr_i)
      OFS_SEL:  rd_next = 32'(sel_i);
      OFS_FILT: rd_next = filt_word;
      OFS_CTRL: rd_next = {30'd0, sel_ok_i && ie_i[sel_i], sel_ok_i && en_i[sel_i]};
      OFS_STAT: rd_next = {31'd0, sel_ok_i && ovf_i[sel_i]};
      OFS_CLO:  rd_next = low_word(cnt_sel);
      OFS_CHI:  rd_next = shadow_q;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_o  <= '0;
      shadow_q <= '0;
      rd_lo_o  <= 1'b0;
    end else begin
      rd_lo_o <= rd_i && (addr_i == OFS_CLO);
      if (rd_i) rdata_o <= rd_next;
      if (rd_i && addr_i == OFS_CLO) shadow_q <= high_word(cnt_sel);
    end
  end
endmodule

// File: rtl/bwmon.sv
module bwmon
  import bwmon_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int PART_W    = 16,
  parameter int GRP_W     = 8,
  parameter int BYTES_W   = 16,
  parameter int CNT_W     = 44,
  parameter bit HAS_IRQ   = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               xfer_valid,
  input  logic [PART_W-1:0]  xfer_part,
  input  logic [GRP_W-1:0]   xfer_grp,
  input  logic [BYTES_W-1:0] xfer_bytes,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [2:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               ovf_irq
);
  localparam int SEL_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  logic [SEL_W-1:0]                 sel_q;
  logic                             sel_ok;
  logic                             wr_filt, wr_ctrl, wr_stat;
  logic [NUM_SLOTS-1:0][CNT_W-1:0]  cnt_all;
  logic [NUM_SLOTS-1:0][PART_W-1:0] fpart_all;
  logic [NUM_SLOTS-1:0][GRP_W-1:0]  fgrp_all;
  logic [NUM_SLOTS-1:0]             en_vec, ie_vec, ovf_vec;
  logic [NUM_SLOTS-1:0]             hit_vec, wrap_vec, clr_vec;
  logic                             rd_lo_q;

  assign sel_ok  = (32'(sel_q) < NUM_SLOTS);
  assign wr_filt = reg_wr && (reg_addr == OFS_FILT);
  assign wr_ctrl = reg_wr && (reg_addr == OFS_CTRL);
  assign wr_stat = reg_wr && (reg_addr == OFS_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= '0;
    else if (reg_wr && reg_addr == OFS_SEL) sel_q <= reg_wdata[SEL_W-1:0];
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    bwmon_slot #(
      .PART_W(PART_W), .GRP_W(GRP_W), .BYTES_W(BYTES_W), .CNT_W(CNT_W)
    ) u_slot (
      .clk(clk), .rst_n(rst_n),
      .sel_i(sel_ok && (sel_q == SEL_W'(g))),
      .wr_filt_i(wr_filt), .wr_ctrl_i(wr_ctrl), .wr_stat_i(wr_stat),
      .wdata_i(reg_wdata),
      .xv_i(xfer_valid), .xpart_i(xfer_part), .xgrp_i(xfer_grp), .xbytes_i(xfer_bytes),
      .cnt_o(cnt_all[g]), .ovf_o(ovf_vec[g]), .en_o(en_vec[g]), .ie_o(ie_vec[g]),
      .fpart_o(fpart_all[g]), .fgrp_o(fgrp_all[g]),
      .hit_o(hit_vec[g]), .wrap_o(wrap_vec[g]), .clr_o(clr_vec[g])
    );
  end

  if (HAS_IRQ) begin : g_irq
    assign ovf_irq = |(ovf_vec & ie_vec);
  end else begin : g_noirq
    assign ovf_irq = 1'b0;
  end

  bwmon_rdmux #(
    .NUM_SLOTS(NUM_SLOTS), .PART_W(PART_W), .GRP_W(GRP_W), .CNT_W(CNT_W), .SEL_W(SEL_W)
  ) u_rdmux (
    .clk(clk), .rst_n(rst_n), .rd_i(reg_rd), .addr_i(reg_addr),
    .sel_i(sel_q), .sel_ok_i(sel_ok),
    .cnt_all_i(cnt_all), .ovf_i(ovf_vec), .en_i(en_vec), .ie_i(ie_vec),
    .fpart_i(fpart_all), .fgrp_i(fgrp_all),
    .rdata_o(reg_rdata), .rd_lo_o(rd_lo_q)
  );
endmodule

// File: rtl/bwmon_chk.sv
module bwmon_chk #(
  parameter int NUM_SLOTS = 4,
  parameter int BYTES_W   = 16,
  parameter int CNT_W     = 44
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic [NUM_SLOTS-1:0]            hit_vec,
  input logic [NUM_SLOTS-1:0]            wrap_vec,
  input logic [NUM_SLOTS-1:0]            clr_vec,
  input logic [NUM_SLOTS-1:0]            en_vec,
  input logic [NUM_SLOTS-1:0]            ovf_vec,
  input logic [NUM_SLOTS-1:0][CNT_W-1:0] cnt_all,
  input logic [BYTES_W-1:0]              xfer_bytes,
  input logic                            rd_lo_q,
  input logic [31:0]                     reg_rdata
);
  // only one slot can be cleared by a single write (R2)
  p_single_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_vec));

  // the reserved top bit of a 31-bit low word stays zero (R7)
  p_lo_reserved_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo_q && CNT_W == 31) |-> !reg_rdata[31]);

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_chk
    p_add_bytes_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_vec[i] && !clr_vec[i] && !wrap_vec[i]) |=>
        cnt_all[i] == $past(cnt_all[i]) + CNT_W'($past(xfer_bytes)));

    p_hold_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_vec[i] && !clr_vec[i]) |=> $stable(cnt_all[i]));

    p_clear_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clr_vec[i] |=> (cnt_all[i] == '0 && !ovf_vec[i]));

    p_ovf_from_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_vec[i]) |-> $past(wrap_vec[i]));
  end
endmodule

bind bwmon bwmon_chk #(
  .NUM_SLOTS(NUM_SLOTS), .BYTES_W(BYTES_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hit_vec(hit_vec), .wrap_vec(wrap_vec),
  .clr_vec(clr_vec), .en_vec(en_vec), .ovf_vec(ovf_vec), .cnt_all(cnt_all),
  .xfer_bytes(xfer_bytes), .rd_lo_q(rd_lo_q), .reg_rdata(reg_rdata)
);

// File: tb/bwmon_tb.sv
`timescale 1ns/1ps
module bwmon_tb;
  localparam logic [63:0] LIM44 = 64'd1 << 44;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        xv = 0, x31v = 0;
  logic [15:0] xpart = 0, x31part = 0;
  logic [7:0]  xgrp = 0, x31grp = 0;
  logic [31:0] xbytes = 0;
  logic [29:0] x31bytes = 0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] rdata0, rdata1;
  logic        irq0, irq1;

  bwmon #(.NUM_SLOTS(4), .BYTES_W(32), .CNT_W(44)) u_dut (
    .clk(clk), .rst_n(rst_n), .xfer_valid(xv), .xfer_part(xpart), .xfer_grp(xgrp),
    .xfer_bytes(xbytes), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata0), .ovf_irq(irq0));

  bwmon #(.NUM_SLOTS(4), .BYTES_W(30), .CNT_W(31)) u_dut31 (
    .clk(clk), .rst_n(rst_n), .xfer_valid(x31v), .xfer_part(x31part), .xfer_grp(x31grp),
    .xfer_bytes(x31bytes), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata1), .ovf_irq(irq1));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // bench model of the 44-bit instance
  logic [63:0] m_cnt [4];
  bit          m_ovf [4], m_en [4], m_ie [4];
  logic [15:0] m_part [4];
  logic [7:0]  m_grp [4];
  int          m_sel;
  logic [31:0] m_shadow;

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic void model_reset();
    for (int s = 0; s < 4; s++) begin
      m_cnt[s] = 0; m_ovf[s] = 0; m_en[s] = 0; m_ie[s] = 0; m_part[s] = 0; m_grp[s] = 0;
    end
    m_sel = 0; m_shadow = 0;
  endfunction

  function automatic void model_edge();
    bit hit [4];
    for (int s = 0; s < 4; s++)
      hit[s] = xv && m_en[s] && xpart == m_part[s] && xgrp == m_grp[s];
    for (int s = 0; s < 4; s++) begin
      bit sel = (m_sel == s);
      bit clr = reg_wr && reg_addr == 3'd2 && sel && reg_wdata[2];
      bit wrp = 0;
      if (clr) begin
        m_cnt[s] = 0; m_ovf[s] = 0;
      end else begin
        if (hit[s]) begin
          logic [63:0] sum = m_cnt[s] + 64'(xbytes);
          wrp = (sum >= LIM44);
          m_cnt[s] = sum % LIM44;
        end
        if (wrp) m_ovf[s] = 1;
        else if (reg_wr && reg_addr == 3'd3 && sel && reg_wdata[0]) m_ovf[s] = 0;
      end
      if (reg_wr && sel && reg_addr == 3'd1) begin
        m_part[s] = reg_wdata[15:0]; m_grp[s] = reg_wdata[23:16];
      end
      if (reg_wr && sel && reg_addr == 3'd2) begin
        m_en[s] = reg_wdata[0]; m_ie[s] = reg_wdata[1];
      end
    end
    if (reg_wr && reg_addr == 3'd0) m_sel = int'(reg_wdata[1:0]);
  endfunction

  function automatic logic [31:0] model_read(input logic [2:0] a);
    case (a)
      3'd0: return 32'(m_sel);
      3'd1: return {8'd0, m_grp[m_sel], m_part[m_sel]};
      3'd2: return {30'd0, m_ie[m_sel], m_en[m_sel]};
      3'd3: return {31'd0, m_ovf[m_sel]};
      3'd4: return m_cnt[m_sel][31:0];
      3'd5: return m_shadow;
      default: return 32'd0;
    endcase
  endfunction

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    reg_wr = 0; reg_rd = 0; xv = 0; x31v = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    step();
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] g0, output logic [31:0] g1,
                    output logic [31:0] e0);
    logic [31:0] hi_pre;
    e0 = model_read(a);
    hi_pre = m_cnt[m_sel][63:32];
    reg_rd = 1; reg_addr = a;
    step();
    if (a == 3'd4) m_shadow = hi_pre;
    g0 = rdata0; g1 = rdata1;
  endtask

  task automatic xfer(input logic [15:0] p, input logic [7:0] g, input logic [31:0] b);
    xv = 1; xpart = p; xgrp = g; xbytes = b;
    step();
  endtask

  task automatic xfer31(input logic [15:0] p, input logic [7:0] g, input logic [29:0] b);
    x31v = 1; x31part = p; x31grp = g; x31bytes = b;
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] g0, g1, e0;
    logic [15:0] parts [3];
    int unsigned seed;
    parts[0] = 16'h1234; parts[1] = 16'h0042; parts[2] = 16'h0007;
    seed = 32'd7;
    void'($urandom(seed));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    check("R1 rdata", 64'(rdata0), 0);
    check("R1 irq", 64'(irq0), 0);
    rd(3'd2, g0, g1, e0); check("R1 ctrl", 64'(g0), 0);
    rd(3'd4, g0, g1, e0); check("R1 count", 64'(g0), 0);
    rd(3'd0, g0, g1, e0); check("R1 select", 64'(g0), 0);

    // R3 / R4: matching and non-matching traffic on slot 0
    wr(3'd1, 32'h0005_1234);
    wr(3'd2, 32'h1);
    xfer(16'h1234, 8'h05, 32'd100);
    rd(3'd4, g0, g1, e0); check("R3 match adds bytes", 64'(g0), 64'd100);
    xfer(16'h1235, 8'h05, 32'd50);
    xfer(16'h1234, 8'h06, 32'd50);
    rd(3'd4, g0, g1, e0); check("R4 tag mismatch ignored", 64'(g0), 64'd100);
    rd(3'd2, g0, g1, e0); check("R4 ctrl readback", 64'(g0), 64'd1);

    // R10: second slot with the same filter, first disabled then enabled
    wr(3'd0, 32'd1);
    wr(3'd1, 32'h0005_1234);
    xfer(16'h1234, 8'h05, 32'd9);
    rd(3'd4, g0, g1, e0); check("R4 disabled slot ignores traffic", 64'(g0), 0);
    wr(3'd2, 32'h1);
    xfer(16'h1234, 8'h05, 32'd7);
    rd(3'd4, g0, g1, e0); check("R10 slot1 counts shared pair", 64'(g0), 64'd7);
    rd(3'd1, g0, g1, e0); check("R2 slot1 filter", 64'(g0), 64'h0005_1234);
    wr(3'd0, 32'd2);
    rd(3'd1, g0, g1, e0); check("R2 slot2 filter untouched", 64'(g0), 0);
    wr(3'd0, 32'd0);
    rd(3'd4, g0, g1, e0); check("R10 slot0 also counted", 64'(g0), 64'd116);

    // R6: shadow of the high word
    xfer(16'h1234, 8'h05, 32'hFFFF_FFFF);
    xfer(16'h1234, 8'h05, 32'hFFFF_FFFF);
    rd(3'd4, g0, g1, e0); check("R6 low word", 64'(g0), 64'h72);
    xfer(16'h1234, 8'h05, 32'hFFFF_FFFF);
    rd(3'd5, g0, g1, e0); check("R6 shadow high word", 64'(g0), 64'd2);
    rd(3'd4, g0, g1, e0); check("R6 low word again", 64'(g0), 64'h71);
    rd(3'd5, g0, g1, e0); check("R6 new high word", 64'(g0), 64'd3);

    // R5: clear collides with a matching transfer
    reg_wr = 1; reg_addr = 3'd2; reg_wdata = 32'h5;
    xv = 1; xpart = 16'h1234; xgrp = 8'h05; xbytes = 32'd33;
    step();
    rd(3'd4, g0, g1, e0); check("R5 clear wins low", 64'(g0), 0);
    rd(3'd5, g0, g1, e0); check("R5 clear wins high", 64'(g0), 0);
    rd(3'd2, g0, g1, e0); check("R5 clear bit reads 0", 64'(g0), 64'd1);

    // random phase against the bench model
    for (int s = 0; s < 4; s++) begin
      wr(3'd0, 32'(s));
      wr(3'd1, {8'd0, 8'($urandom % 2), parts[$urandom % 3]});
      wr(3'd2, 32'(($urandom % 4) != 0));
    end
    for (int k = 0; k < 600; k++) begin
      int r = int'($urandom % 10);
      if (r < 6) begin
        xfer(parts[$urandom % 3], 8'($urandom % 2), $urandom);
      end else if (r == 6) begin
        wr(3'd0, 32'($urandom % 4));
        rd(3'd4, g0, g1, e0); check("R3 random low word", 64'(g0), 64'(e0));
        rd(3'd5, g0, g1, e0); check("R6 random high word", 64'(g0), 64'(e0));
      end else if (r == 7) begin
        reg_wr = 1; reg_addr = 3'd2; reg_wdata = {29'd0, 1'b1, 1'b0, m_en[m_sel]};
        xv = 1; xpart = parts[$urandom % 3]; xgrp = 8'($urandom % 2); xbytes = $urandom;
        step();
      end else begin
        step();
      end
    end
    for (int s = 0; s < 4; s++) begin
      wr(3'd0, 32'(s));
      rd(3'd4, g0, g1, e0); check("R10 final low word", 64'(g0), 64'(e0));
      rd(3'd5, g0, g1, e0); check("R6 final high word", 64'(g0), 64'(e0));
      rd(3'd1, g0, g1, e0); check("R2 final filter", 64'(g0), 64'(e0));
    end

    // R7 / R8 / R9: 31-bit instance on slot 3
    wr(3'd0, 32'd3);
    wr(3'd1, 32'h0002_0009);
    wr(3'd2, 32'h3);
    xfer31(16'd9, 8'd2, 30'h3FFF_FFFF);
    xfer31(16'd9, 8'd2, 30'h3FFF_FFFF);
    rd(3'd4, g0, g1, e0); check("R7 31-bit near top", 64'(g1), 64'h7FFF_FFFE);
    check("R9 irq low before wrap", 64'(irq1), 0);
    xfer31(16'd9, 8'd2, 30'h3FFF_FFFF);
    check("R9 irq after wrap", 64'(irq1), 1);
    rd(3'd4, g0, g1, e0); check("R8 wrapped sum", 64'(g1), 64'h3FFF_FFFD);
    rd(3'd5, g0, g1, e0); check("R7 high word zero", 64'(g1), 0);
    rd(3'd3, g0, g1, e0); check("R8 sticky flag", 64'(g1), 1);
    wr(3'd3, 32'h1);
    rd(3'd3, g0, g1, e0); check("R8 flag cleared by write 1", 64'(g1), 0);
    check("R9 irq drops with flag", 64'(irq1), 0);
    wr(3'd2, 32'h1);
    xfer31(16'd9, 8'd2, 30'h3FFF_FFFF);
    xfer31(16'd9, 8'd2, 30'h3FFF_FFFF);
    rd(3'd4, g0, g1, e0); check("R8 second wrap sum", 64'(g1), 64'h3FFF_FFFB);
    check("R9 irq masked by enable", 64'(irq1), 0);
    rd(3'd3, g0, g1, e0); check("R8 flag set again", 64'(g1), 1);
    wr(3'd2, 32'h3);
    check("R9 irq when enabled", 64'(irq1), 1);
    check("R9 main instance no irq", 64'(irq0), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule